// File: doc/BRIEF.md
# Interface adapter interrupt flag and enable register front end

This block is the register-file front end of a classic versatile interface adapter. A host reaches it over a simple byte bus. The register index is taken from a four-bit field of the bus address. The block keeps the interrupt flags and the interrupt enables, and it drives one level-sensitive interrupt line. It also holds the plain storage registers: the two ports, their direction registers, shift data, auxiliary control, peripheral control and the second copy of port A that has no handshake.

The timer and shift engines are separate blocks. They raise flags here through one-cycle set strobes. A flag is cleared in one of three ways: by writing ones to the flag register, by reading the shift-data register, or by the timer-register accesses that acknowledge a timer. Read data is combinational from the address. The side effects of a read take place at the clock edge where `bus_rd` is high.

Top module: `via_irq_regs`

## Requirements
- R1: The register index is `bus_addr[12:9]`. The address bits below bit 9 have no effect on which register is accessed.
- R2: The storage indexes 0, 1, 2, 3, 10, 11, 12 and 15 each hold the last byte written to them. `bus_rdata` returns that byte combinationally while the index is on the address.
- R3: Indexes 4 to 9 belong to the external timer block. They read as 0x00, and a write to them stores nothing.
- R4: The strobes set these flag bits: `set_sr` bit 2 (0x04), `set_sd` bit 3 (0x08), `set_sc` bit 4 (0x10), `set_t2` bit 5 (0x20) and `set_t1` bit 6 (0x40). Flag bits 0 and 1 always read 0. A flag stays set until it is cleared.
- R5: A read of index 13 returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag is set whose enable is also set.
- R6: A write to index 13 clears each flag whose bit 6:0 is written as 1 and leaves the other flags unchanged. Bit 7 of the write is ignored.
- R7: A write to index 14 with bit 7 = 1 sets each enable whose bit 6:0 is 1. A write with bit 7 = 0 clears each enable whose bit 6:0 is 1. Enables written as 0 keep their value.
- R8: A read of index 14 returns the enables in bits 6:0, with bit 7 always 1.
- R9: A read of index 10 clears flag bits 2, 3 and 4 (mask 0x1C) and leaves bits 5 and 6 unchanged.
- R10: Flag bit 6 is cleared by a read of index 4, a write of index 5 or a write of index 7. Flag bit 5 is cleared by a read of index 8. Reads of indexes 5, 6, 7 and 9 clear no flag.
- R11: `irq` is 1 exactly when (flags AND enables) has bit 2 or bit 6 set.
- R12: When a set strobe and a clearing access hit the same flag in the same cycle, the flag ends up set.
- R13: After reset every stored register, flag and enable is 0. Index 14 therefore reads 0x80, every other index reads 0x00, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 13 | Byte address; bits 12:9 select the register |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe; read side effects happen at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| set_sr | input | 1 | Set strobe for flag bit 2 |
| set_sd | input | 1 | Set strobe for flag bit 3 |
| set_sc | input | 1 | Set strobe for flag bit 4 |
| set_t2 | input | 1 | Set strobe for flag bit 5 |
| set_t1 | input | 1 | Set strobe for flag bit 6 |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 13-bit address with the index at bit 9, and 8-bit registers. With this configuration the whole index space of 16 registers and every one of the 256 enable-write bytes can be swept. The bench also runs all 1024 pairings of the five flag bits with the five matching enables, which covers the summary bit and the interrupt line for every combination. It further sweeps all 128 clear masks and drives each clearing access in the same cycle as a competing set strobe.

// File: rtl/via_pkg.sv
package via_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned FLAG_W = 7;
    localparam int unsigned IDX_W  = 4;
    localparam int unsigned N_IDX  = 1 << IDX_W;

    typedef enum logic [IDX_W-1:0] {
        IDX_PORT_B   = 4'd0,
        IDX_PORT_A   = 4'd1,
        IDX_DIR_B    = 4'd2,
        IDX_DIR_A    = 4'd3,
        IDX_TA_CNT_L = 4'd4,
        IDX_TA_CNT_H = 4'd5,
        IDX_TA_LAT_L = 4'd6,
        IDX_TA_LAT_H = 4'd7,
        IDX_TB_CNT_L = 4'd8,
        IDX_TB_CNT_H = 4'd9,
        IDX_SHIFT    = 4'd10,
        IDX_AUX      = 4'd11,
        IDX_PERIPH   = 4'd12,
        IDX_FLAGS    = 4'd13,
        IDX_ENABLES  = 4'd14,
        IDX_PORT_A_Q = 4'd15
    } via_idx_e;

    localparam int unsigned BIT_SR = 2;
    localparam int unsigned BIT_SD = 3;
    localparam int unsigned BIT_SC = 4;
    localparam int unsigned BIT_T2 = 5;
    localparam int unsigned BIT_T1 = 6;

    localparam logic [FLAG_W-1:0] SHIFT_MASK = 7'h1C;
    localparam logic [FLAG_W-1:0] IRQ_MASK   = 7'h44;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] enables;
    } irq_state_t;

    function automatic logic is_storage(input int unsigned i);
        return (i <= 3) || (i == 10) || (i == 11) || (i == 12) || (i == 15);
    endfunction
endpackage

// File: rtl/via_addr_decode.sv
module via_addr_decode
    import via_pkg::*;
#(
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned IDX_LSB = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output via_idx_e          idx,
    output logic [N_IDX-1:0]  sel
);
    logic unused_low_addr;
    assign unused_low_addr = ^addr[IDX_LSB-1:0];

    assign idx = via_idx_e'(addr[IDX_LSB +: IDX_W]);

    for (genvar i = 0; i < N_IDX; i++) begin : g_sel
        assign sel[i] = (addr[IDX_LSB +: IDX_W] == IDX_W'(i));
    end
endmodule

// File: rtl/via_store.sv
module via_store
    import via_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [N_IDX-1:0]            sel,
    input  logic [REG_W-1:0]            wdata,
    output logic [N_IDX-1:0][REG_W-1:0] store_q
);
    for (genvar i = 0; i < N_IDX; i++) begin : g_reg
        if (is_storage(i)) begin : g_keep
            logic [REG_W-1:0] val_d, val_q;
            always_comb begin
                val_d = val_q;
                if (wr && sel[i]) val_d = wdata;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= '0;
                else        val_q <= val_d;
            end
            assign store_q[i] = val_q;
        end else begin : g_none
            logic unused_sel;
            assign unused_sel = sel[i];
            assign store_q[i] = '0;
        end
    end
endmodule

// File: rtl/via_irq_core.sv
module via_irq_core
    import via_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic              hit_flags,
    input  logic              hit_enables,
    input  logic              hit_shift,
    input  logic              hit_ta_cnt_l,
    input  logic              hit_ta_cnt_h,
    input  logic              hit_ta_lat_h,
    input  logic              hit_tb_cnt_l,
    input  logic [REG_W-1:0]  wdata,
    input  logic [FLAG_W-1:0] set_vec,
    output logic [FLAG_W-1:0] flags_q,
    output logic [FLAG_W-1:0] enables_q
);
    irq_state_t st_d, st_q;
    logic [FLAG_W-1:0] clr;

    always_comb begin
        clr = '0;
        if (wr && hit_flags) clr = clr | wdata[FLAG_W-1:0];
        if (rd && hit_shift) clr = clr | SHIFT_MASK;
        if ((rd && hit_ta_cnt_l) || (wr && hit_ta_cnt_h) || (wr && hit_ta_lat_h))
            clr[BIT_T1] = 1'b1;
        if (rd && hit_tb_cnt_l) clr[BIT_T2] = 1'b1;

        st_d = st_q;
        st_d.flags = (st_q.flags & ~clr) | set_vec;
        if (wr && hit_enables) begin
            if (wdata[REG_W-1]) st_d.enables = st_q.enables | wdata[FLAG_W-1:0];
            else                st_d.enables = st_q.enables & ~wdata[FLAG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q   = st_q.flags;
    assign enables_q = st_q.enables;
endmodule

// File: rtl/via_irq_regs.sv
module via_irq_regs
    import via_pkg::*;
#(
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned IDX_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              set_sr,
    input  logic              set_sd,
    input  logic              set_sc,
    input  logic              set_t2,
    input  logic              set_t1,
    output logic              irq
);
    via_idx_e                    idx;
    logic [N_IDX-1:0]            sel;
    logic [N_IDX-1:0][REG_W-1:0] store_q;
    logic [FLAG_W-1:0]           flags_q, enables_q, set_vec;

    assign set_vec = {set_t1, set_t2, set_sc, set_sd, set_sr, 2'b00};

    via_addr_decode #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_dec (
        .addr(bus_addr), .idx(idx), .sel(sel)
    );

    via_store u_store (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel),
        .wdata(bus_wdata), .store_q(store_q)
    );

    via_irq_core u_core (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd),
        .hit_flags(sel[IDX_FLAGS]), .hit_enables(sel[IDX_ENABLES]),
        .hit_shift(sel[IDX_SHIFT]), .hit_ta_cnt_l(sel[IDX_TA_CNT_L]),
        .hit_ta_cnt_h(sel[IDX_TA_CNT_H]), .hit_ta_lat_h(sel[IDX_TA_LAT_H]),
        .hit_tb_cnt_l(sel[IDX_TB_CNT_L]), .wdata(bus_wdata),
        .set_vec(set_vec), .flags_q(flags_q), .enables_q(enables_q)
    );

    always_comb begin
        case (idx)
            IDX_FLAGS:   bus_rdata = {|(flags_q & enables_q), flags_q};
            IDX_ENABLES: bus_rdata = {1'b1, enables_q};
            default:     bus_rdata = store_q[idx];
        endcase
    end

    assign irq = |(flags_q & enables_q & IRQ_MASK);
endmodule

// File: rtl/via_irq_regs_chk.sv
module via_irq_regs_chk
    import via_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  bus_idx,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              set_sr,
    input logic              set_sd,
    input logic              set_sc,
    input logic              set_t2,
    input logic              set_t1,
    input logic              irq,
    input logic [FLAG_W-1:0] flags_q,
    input logic [FLAG_W-1:0] enables_q
);
    logic any_set;
    assign any_set = set_sr | set_sd | set_sc | set_t2 | set_t1;

    assert_set_wins_t1_R12: assert property (@(posedge clk) disable iff (!rst_n)
        set_t1 |=> flags_q[BIT_T1]);
    assert_set_wins_sr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        set_sr |=> flags_q[BIT_SR]);
    assert_unused_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[1:0] == 2'b00);
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_idx == 4'd13 && !any_set) |=> ((flags_q & $past(bus_wdata[FLAG_W-1:0])) == '0));
    assert_enable_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_idx == 4'd14 && bus_wdata[7])
        |=> ((enables_q & $past(bus_wdata[FLAG_W-1:0])) == $past(bus_wdata[FLAG_W-1:0])));
    assert_enable_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_idx == 4'd14 && !bus_wdata[7])
        |=> ((enables_q & $past(bus_wdata[FLAG_W-1:0])) == '0));
    assert_enable_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx == 4'd14) |-> (bus_rdata == {1'b1, enables_q}));
    assert_shift_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_idx == 4'd10 && !set_sr && !set_sd && !set_sc) |=> (flags_q[4:2] == 3'b000));
    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set_sr || set_t1 || (bus_wr && bus_idx == 4'd14)));
endmodule

bind via_irq_regs via_irq_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_idx(bus_addr[IDX_LSB +: 4]),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .set_sr(set_sr), .set_sd(set_sd), .set_sc(set_sc), .set_t2(set_t2), .set_t1(set_t1),
    .irq(irq), .flags_q(flags_q), .enables_q(enables_q)
);

// File: tb/via_irq_regs_tb.sv
module via_irq_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        set_sr = 0, set_sd = 0, set_sc = 0, set_t2 = 0, set_t1 = 0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [6:0] m_en = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    via_irq_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_sr(set_sr), .set_sd(set_sd),
        .set_sc(set_sc), .set_t2(set_t2), .set_t1(set_t1), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] mk_addr(input int idx, input int junk);
        return {4'(idx), 9'(junk)};
    endfunction

    task automatic wr(input int idx, input int data, input int junk = 0);
        bus_addr = mk_addr(idx, junk); bus_wdata = 8'(data); bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [7:0] v, input int junk = 0);
        bus_addr = mk_addr(idx, junk); bus_rd = 1'b1; #1; v = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input int idx, output logic [7:0] v);
        bus_addr = mk_addr(idx, 0); #1; v = bus_rdata;
    endtask

    task automatic pulse(input logic [4:0] m);
        {set_t1, set_t2, set_sc, set_sd, set_sr} = m;
        @(posedge clk); @(negedge clk);
        {set_t1, set_t2, set_sc, set_sd, set_sr} = '0;
    endtask

    task automatic set_en(input logic [6:0] e);
        wr(14, 8'h7F); wr(14, {1'b1, e}); m_en = e;
    endtask

    task automatic flags_is(input string req, input logic [6:0] f);
        logic [7:0] v;
        peek(13, v);
        check(req, v, {|(f & m_en), f});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [6:0] f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state
        for (int i = 0; i < 16; i++) begin
            peek(i, v);
            check("R13 reset read", v, (i == 14) ? 8'h80 : 8'h00);
        end
        check("R13 reset irq", irq, 0);

        // R1, R2: storage registers with address junk below bit 9
        for (int i = 0; i < 16; i++)
            if (i <= 3 || (i >= 10 && i <= 12) || i == 15) wr(i, (i * 37 + 5) & 8'hFF, i * 29 + 1);
        for (int i = 0; i < 16; i++)
            if (i <= 3 || (i >= 10 && i <= 12) || i == 15) begin
                bus_addr = mk_addr(i, 511 - i); #1;
                check("R1 R2 storage readback", bus_rdata, (i * 37 + 5) & 8'hFF);
            end
        for (int d = 0; d < 256; d++) begin
            wr(11, d, d * 2);
            peek(11, v);
            check("R2 aux sweep", v, d);
        end

        // R3: timer indexes
        for (int i = 4; i <= 9; i++) begin
            wr(i, 8'hFF);
            peek(i, v);
            check("R3 timer index reads zero", v, 0);
        end

        // R7, R8: every enable write byte
        for (int d = 0; d < 256; d++) begin
            wr(14, d);
            if (d[7]) m_en = m_en | 7'(d); else m_en = m_en & ~7'(d);
            peek(14, v);
            check("R7 R8 enable write", v, {1'b1, m_en});
        end

        // R4, R5, R11: all flag / enable pairings
        for (int fs = 0; fs < 32; fs++)
            for (int es = 0; es < 32; es++) begin
                wr(13, 8'h7F);
                set_en(7'(es << 2));
                pulse(5'(fs));
                peek(13, v);
                check("R4 R5 flag read", v, {((fs & es) != 0), 7'(fs << 2)});
                check("R11 irq level", irq, ((fs & es & 5'b10001) != 0));
            end

        // R6: all clear masks, bit 7 varied
        set_en(7'h00);
        for (int m = 0; m < 128; m++) begin
            pulse(5'h1F);
            wr(13, {m[0], 7'(m)});
            flags_is("R6 clear mask", 7'h7C & ~7'(m));
        end

        // R9: shift data read
        wr(13, 8'h7F);
        wr(10, 8'hA5);
        pulse(5'h1F);
        rd(10, v);
        check("R9 shift data value", v, 8'hA5);
        flags_is("R9 shift flags cleared", 7'h60);

        // R10: timer acknowledges
        wr(13, 8'h7F); pulse(5'h1F); rd(4, v);  flags_is("R10 read idx4", 7'h3C);
        pulse(5'h1F);  wr(5, 8'h12);            flags_is("R10 write idx5", 7'h3C);
        pulse(5'h1F);  wr(7, 8'h34);            flags_is("R10 write idx7", 7'h3C);
        pulse(5'h1F);  rd(8, v);                flags_is("R10 read idx8", 7'h5C);
        pulse(5'h1F);
        rd(5, v); rd(6, v); rd(7, v); rd(9, v);
        flags_is("R10 other reads keep flags", 7'h7C);

        // R12: set beats clear in the same cycle
        wr(13, 8'h7F);
        set_t1 = 1'b1; wr(13, 8'h7F); set_t1 = 1'b0;
        flags_is("R12 set vs flag write", 7'h40);
        wr(13, 8'h7F);
        set_sr = 1'b1; rd(10, v); set_sr = 1'b0;
        flags_is("R12 set vs shift read", 7'h04);
        wr(13, 8'h7F);
        set_t1 = 1'b1; rd(4, v); set_t1 = 1'b0;
        flags_is("R12 set vs timer read", 7'h40);
        set_en(7'h40);
        check("R11 irq from timer one", irq, 1);
        f = 7'h00;
        wr(13, 8'h40);
        flags_is("R6 final clear", f);
        check("R11 irq drops", irq, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule